// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block lets an I2C controller read and write a 256-byte memory that sits behind a simple synchronous memory port. The SCL and SDA wires are oversampled by the system clock through short synchronizer chains. The block recognizes start, repeated start and stop conditions and frames the bits into bytes. It answers to one 7-bit device address, built from a fixed four-bit family code and three strap inputs. SDA is only ever pulled low, so the block behaves as one open-drain participant on a wired-AND line.

A single byte-wide address counter serves both directions. In a write transaction, the first byte after the device address loads the counter. Each later byte is written to the memory port and advances the counter inside its 8-byte row. In a read transaction, bytes are fetched from the current counter position and the counter steps linearly through the whole space. A short write that carries only a memory address, followed by a repeated start, therefore positions the counter for a read. A busy input models a nonvolatile commit in progress. While it is high, the block refuses its own address, so the controller can poll until the commit finishes.

Top module: `i2c_mem_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal binary 1010 followed by strap bits 2..1..0, with bit 0 selecting read (1) or write (0). Acknowledge means SDA is held low during the 9th clock. All bytes travel most significant bit first.
- R2: After an address byte that does not match, the target leaves SDA released and writes nothing until the next start condition, whatever bytes follow.
- R3: While busy_i is high during the address byte, the target does not acknowledge even a matching address and then ignores the bus as in R2.
- R4: In a write transaction, the byte after the address loads the address counter. Every later byte is acknowledged and produces exactly one single-cycle mem_we_o pulse carrying that byte at the counter address.
- R5: During writes the counter increments only its low three bits, so data wraps within the current 8-byte row. For example, three bytes written from 06h land at 06h, 07h and 00h, and the counter is left at 01h.
- R6: A read returns bytes starting at the current counter value. After each byte the counter increments across row boundaries, rolling from FFh to 00h.
- R7: An address-only write followed by a repeated start and a read address makes the read begin at the memory address just sent.
- R8: A zero from the controller in the 9th bit of a read byte requests another byte. A one ends the read: SDA stays released until the next start.
- R9: After reset, and after any stop condition, SDA is released. After reset the counter is 00h and mem_we_o is low.
- R10: A start or repeated start in the middle of a byte discards the partial byte and begins a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL wire |
| sda_i | input | 1 | Sensed level of the SDA wire |
| strap_i | input | 3 | Low three bits of the device address |
| busy_i | input | 1 | Commit in progress; address is refused |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr_o | output | 8 | Current address counter, used for reads and writes |
| mem_wdata_o | output | 8 | Byte to store |
| mem_we_o | output | 1 | Single-cycle write strobe |
| mem_rdata_i | input | 8 | Byte at mem_addr_o, read combinationally |

## Verification
The hardest conditions to reach are the counter edges: a write that runs past the end of a row, and a read that crosses FFh. Each needs a precise sequence of address, memory address and data bytes, and for a read a repeated start, before the edge is reached. The bench drives a bit-level bus master that places these sequences directly. It positions the counter at 06h and FEh, then mixes in random write and read bursts with random start addresses, lengths and strap values. After each burst, the bench compares the whole memory image and the bytes it reads back against a reference counter and a shadow memory.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MADDR,
        ST_MADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } xfer_state_e;

    typedef enum logic [1:0] {
        CTR_HOLD,
        CTR_LOAD,
        CTR_ROW_INC,
        CTR_LIN_INC
    } ctr_op_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output i2c_mem_pkg::bus_evt_t evt_o
);
    localparam int DEPTH = STAGES + 1;

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prev;

    assign raw = {sda_i, scl_i};

    // One chain per wire: STAGES synchronizer flops plus one history flop.
    for (genvar g = 0; g < 2; g++) begin : g_wire
        logic [DEPTH-1:0] chain_d;
        logic [DEPTH-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[DEPTH-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign cur[g]  = chain_q[DEPTH-2];
        assign prev[g] = chain_q[DEPTH-1];
    end

    always_comb begin
        evt_o.scl_rise = cur[0] & ~prev[0];
        evt_o.scl_fall = ~cur[0] & prev[0];
        evt_o.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
        evt_o.stop     = cur[0] & prev[0] & ~prev[1] & cur[1];
        evt_o.sda      = cur[1];
    end

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
    parameter int AW       = 8,
    parameter int ROW_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  i2c_mem_pkg::ctr_op_e op_i,
    input  logic [AW-1:0]        load_i,
    output logic [AW-1:0]        ctr_o
);
    import i2c_mem_pkg::*;

    logic [AW-1:0]       ctr_d;
    logic [AW-1:0]       ctr_q;
    logic [ROW_BITS-1:0] col_next;

    assign col_next = ctr_q[ROW_BITS-1:0] + ROW_BITS'(1);

    always_comb begin
        ctr_d = ctr_q;
        unique case (op_i)
            CTR_LOAD:    ctr_d = load_i;
            CTR_ROW_INC: ctr_d = {ctr_q[AW-1:ROW_BITS], col_next};
            CTR_LIN_INC: ctr_d = ctr_q + AW'(1);
            default:     ctr_d = ctr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign ctr_o = ctr_q;

    AST_ROW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CTR_ROW_INC) |=> (ctr_q[AW-1:ROW_BITS] == $past(ctr_q[AW-1:ROW_BITS]))); // R5
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CTR_LIN_INC) |=> (ctr_q == $past(ctr_q) + AW'(1))); // R6

endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl #(
    parameter logic [3:0] DEV_ID = 4'b1010
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  i2c_mem_pkg::bus_evt_t evt_i,
    input  logic [2:0]            strap_i,
    input  logic                  busy_i,
    input  logic [7:0]            rdata_i,
    output i2c_mem_pkg::ctr_op_e  ctr_op_o,
    output logic [7:0]            ctr_load_o,
    output logic                  we_o,
    output logic [7:0]            wdata_o,
    output logic                  sda_pull_o
);
    import i2c_mem_pkg::*;

    typedef struct packed {
        xfer_state_e st;
        logic [3:0]  nbit;
        logic [7:0]  shreg;
        logic        pull;
        logic        rnw;
        logic        mack;
        logic        we;
        logic [7:0]  wdata;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    logic      addr_hit;
    logic      byte_done;
    logic [7:0] shifted;

    assign addr_hit  = (r_q.shreg[7:1] == {DEV_ID, strap_i}) && !busy_i;
    assign byte_done = evt_i.scl_fall && (r_q.nbit == 4'd8);
    assign shifted   = {r_q.shreg[6:0], 1'b0};

    always_comb begin
        r_d        = r_q;
        r_d.we     = 1'b0;
        ctr_op_o   = CTR_HOLD;
        ctr_load_o = r_q.shreg;

        if (evt_i.start) begin
            r_d.st   = ST_ADDR;
            r_d.nbit = '0;
            r_d.pull = 1'b0;
        end else if (evt_i.stop) begin
            r_d.st   = ST_IDLE;
            r_d.nbit = '0;
            r_d.pull = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_MADDR, ST_WDATA: begin
                    if (evt_i.scl_rise && r_q.nbit < 4'd8) begin
                        r_d.shreg = {r_q.shreg[6:0], evt_i.sda};
                        r_d.nbit  = r_q.nbit + 4'd1;
                    end else if (byte_done) begin
                        r_d.nbit = '0;
                        if (r_q.st == ST_ADDR) begin
                            if (addr_hit) begin
                                r_d.pull = 1'b1;
                                r_d.rnw  = r_q.shreg[0];
                                r_d.st   = ST_ADDR_ACK;
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else if (r_q.st == ST_MADDR) begin
                            ctr_op_o = CTR_LOAD;
                            r_d.pull = 1'b1;
                            r_d.st   = ST_MADDR_ACK;
                        end else begin
                            r_d.we    = 1'b1;
                            r_d.wdata = r_q.shreg;
                            r_d.pull  = 1'b1;
                            r_d.st    = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK, ST_MADDR_ACK, ST_WDATA_ACK: begin
                    if (evt_i.scl_fall) begin
                        r_d.pull = 1'b0;
                        if (r_q.st == ST_ADDR_ACK && r_q.rnw) begin
                            r_d.shreg = rdata_i;
                            r_d.pull  = ~rdata_i[7];
                            r_d.st    = ST_RDATA;
                            ctr_op_o  = CTR_LIN_INC;
                        end else if (r_q.st == ST_ADDR_ACK) begin
                            r_d.st = ST_MADDR;
                        end else begin
                            r_d.st = ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (evt_i.scl_rise && r_q.nbit < 4'd8) begin
                        r_d.nbit = r_q.nbit + 4'd1;
                    end else if (byte_done) begin
                        r_d.nbit = '0;
                        r_d.pull = 1'b0;
                        r_d.st   = ST_RACK;
                    end else if (evt_i.scl_fall) begin
                        r_d.shreg = shifted;
                        r_d.pull  = ~shifted[7];
                    end
                end
                ST_RACK: begin
                    if (evt_i.scl_rise) begin
                        r_d.mack = ~evt_i.sda;
                    end else if (evt_i.scl_fall) begin
                        if (r_q.mack) begin
                            r_d.shreg = rdata_i;
                            r_d.pull  = ~rdata_i[7];
                            r_d.st    = ST_RDATA;
                            ctr_op_o  = CTR_LIN_INC;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end

        // Advance the counter the cycle after the strobe, so the strobe
        // sees the address the byte belongs to.
        if (r_q.we) ctr_op_o = CTR_ROW_INC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign we_o       = r_q.we;
    assign wdata_o    = r_q.wdata;
    assign sda_pull_o = r_q.pull;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !r_q.pull && !r_q.we); // R2
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADDR && busy_i) |=> (r_q.st != ST_ADDR_ACK)); // R3
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o); // R4
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.stop |=> !sda_pull_o); // R9
    AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.start |=> (r_q.st == ST_ADDR) && (r_q.nbit == 4'd0)); // R10

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
    parameter int         ROW_BITS    = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       busy_i,
    output logic       sda_pull_o,
    output logic [7:0] mem_addr_o,
    output logic [7:0] mem_wdata_o,
    output logic       mem_we_o,
    input  logic [7:0] mem_rdata_i
);
    import i2c_mem_pkg::*;

    localparam int AW = BYTE_W;

    bus_evt_t      evt;
    ctr_op_e       ctr_op;
    logic [AW-1:0] ctr_load;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2c_xfer_ctrl #(.DEV_ID(DEV_ID)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .strap_i    (strap_i),
        .busy_i     (busy_i),
        .rdata_i    (mem_rdata_i),
        .ctr_op_o   (ctr_op),
        .ctr_load_o (ctr_load),
        .we_o       (mem_we_o),
        .wdata_o    (mem_wdata_o),
        .sda_pull_o (sda_pull_o)
    );

    i2c_addr_ctr #(.AW(AW), .ROW_BITS(ROW_BITS)) i_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (ctr_op),
        .load_i (ctr_load),
        .ctr_o  (mem_addr_o)
    );

endmodule

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;

    localparam int CLK_NS = 10;
    localparam int QTR    = 6;
    localparam int HIGH   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b110;
    logic       busy = 1'b0;
    logic       sda_pull;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we;
    logic       sda_line;

    logic [7:0] bmem [256];
    logic [7:0] rmem [256];
    logic [7:0] rc;
    logic       pull_seen;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign mem_rdata = bmem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr] <= mem_wdata;
        if (sda_pull) pull_seen <= 1'b1;
    end

    i2c_mem_target i_i2c_mem_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .strap_i     (strap),
        .busy_i      (busy),
        .sda_pull_o  (sda_pull),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_rdata_i (mem_rdata)
    );

    function automatic logic [7:0] row_next(logic [7:0] a);
        return {a[7:3], a[2:0] + 3'd1};
    endfunction

    function automatic logic [7:0] lin_next(logic [7:0] a);
        return a + 8'd1;
    endfunction

    function automatic logic [7:0] addr_byte(logic [2:0] s, logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(QTR);
        scl_m = 1'b1; tick(HIGH);
        sda_m = 1'b0; tick(HIGH);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(QTR);
        scl_m = 1'b1; tick(HIGH);
        sda_m = 1'b1; tick(HIGH);
    endtask

    task automatic bit_xfer(input logic b, output logic seen);
        sda_m = b; tick(QTR);
        scl_m = 1'b1; tick(HIGH/2);
        seen = sda_line; tick(HIGH/2);
        scl_m = 1'b0; tick(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            d[i] = s;
        end
        bit_xfer(~mack, s);
    endtask

    task automatic mem_compare(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 256; i++) begin
            if (bmem[i] !== rmem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, int'(bmem[first]), int'(rmem[first]));
    endtask

    // Write: address W, memory address, n data bytes, stop.
    task automatic do_write(input logic [7:0] ma, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), ack);
        check(ack, "R1 write address ack", int'(ack), 1);
        send_byte(ma, ack);
        check(ack, "R4 memory address ack", int'(ack), 1);
        rc = ma;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check(ack, "R4 data ack", int'(ack), 1);
            rmem[rc] = d;
            rc = row_next(rc);
        end
        bus_stop();
        tick(4);
        mem_compare(req);
    endtask

    // Read n bytes, optionally after an address-only write.
    task automatic do_read(input logic dummy, input logic [7:0] ma, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        if (dummy) begin
            send_byte(addr_byte(strap, 1'b0), ack);
            check(ack, "R7 dummy address ack", int'(ack), 1);
            send_byte(ma, ack);
            check(ack, "R7 dummy memory address ack", int'(ack), 1);
            rc = ma;
            bus_start();
        end
        send_byte(addr_byte(strap, 1'b1), ack);
        check(ack, "R1 read address ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            check(d == rmem[rc], req, int'(d), int'(rmem[rc]));
            rc = lin_next(rc);
        end
        tick(2);
        check(!sda_pull, "R8 released after NACK", int'(sda_pull), 0);
        bus_stop();
        tick(2);
        check(!sda_pull, "R9 released after stop", int'(sda_pull), 0);
    endtask

    initial begin
        logic ack;
        logic s;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'(i * 7 + 3);
            rmem[i] = 8'(i * 7 + 3);
        end
        pull_seen = 1'b0;
        rc = 8'h00;
        tick(5);
        check(!sda_pull, "R9 reset SDA released", int'(sda_pull), 0);
        rst_n = 1'b1;
        tick(5);
        check(!sda_pull && !mem_we, "R9 reset outputs idle", int'({sda_pull, mem_we}), 0);
        check(mem_addr == 8'h00, "R9 reset counter", int'(mem_addr), 0);

        // R5: 3 bytes from 06h wrap to 00h; counter left at 01h
        bus_start();
        send_byte(addr_byte(strap, 1'b0), ack);
        send_byte(8'h06, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        bus_stop();
        tick(4);
        rmem[8'h06] = 8'h11; rmem[8'h07] = 8'h22; rmem[8'h00] = 8'h33;
        rc = 8'h01;
        check(bmem[8'h00] == 8'h33, "R5 row wrap to 00h", int'(bmem[8'h00]), 8'h33);
        check(bmem[8'h08] == rmem[8'h08], "R5 next row untouched", int'(bmem[8'h08]), int'(rmem[8'h08]));
        check(mem_addr == 8'h01, "R5 counter after wrap", int'(mem_addr), 1);

        // R6: read from current counter without repositioning
        do_read(1'b0, 8'h00, 2, "R6 read from current counter");
        // R6/R7: dummy write to FEh, read across FFh
        do_read(1'b1, 8'hFE, 4, "R7 R6 read across FFh");
        check(mem_addr == 8'h02, "R6 counter rolled", int'(mem_addr), 2);

        // R2: wrong address, following bytes ignored
        tick(2);
        pull_seen = 1'b0;
        bus_start();
        send_byte({4'b1010, ~strap, 1'b0}, ack);
        check(!ack, "R2 mismatch not acked", int'(ack), 0);
        send_byte(8'h10, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        tick(4);
        check(!pull_seen, "R2 SDA never pulled", int'(pull_seen), 0);
        mem_compare("R2 no write after mismatch");

        // R3: busy refuses address, then polling succeeds
        busy = 1'b1;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), ack);
        check(!ack, "R3 busy refuses address", int'(ack), 0);
        bus_stop();
        busy = 1'b0;
        tick(4);
        bus_start();
        send_byte(addr_byte(strap, 1'b0), ack);
        check(ack, "R3 acked once not busy", int'(ack), 1);
        bus_stop();
        tick(4);

        // R10: start in the middle of a byte restarts framing
        bus_start();
        bit_xfer(1'b1, s); bit_xfer(1'b0, s); bit_xfer(1'b1, s); bit_xfer(1'b0, s);
        bus_start();
        send_byte(addr_byte(strap, 1'b0), ack);
        check(ack, "R10 address after mid-byte start", int'(ack), 1);
        send_byte(8'h40, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        tick(4);
        rmem[8'h40] = 8'h5A;
        rc = 8'h41;
        mem_compare("R10 write after restart");

        // R8: NACK ends read, extra clocks see no drive
        bus_start();
        send_byte(addr_byte(strap, 1'b1), ack);
        recv_byte(1'b0, mem_rdata_unused);
        rc = lin_next(rc);
        tick(2);
        pull_seen = 1'b0;
        for (int i = 0; i < 9; i++) bit_xfer(1'b1, s);
        check(!pull_seen, "R8 no drive after NACK", int'(pull_seen), 0);
        bus_stop();
        tick(4);

        // Random bursts with random straps
        for (int t = 0; t < 26; t++) begin
            strap = 3'($urandom);
            if ($urandom_range(1, 0) == 1)
                do_write(8'($urandom), int'($urandom_range(10, 1)), "R4 R5 random write");
            else
                do_read($urandom_range(1, 0) == 1, 8'($urandom), int'($urandom_range(6, 1)),
                        "R6 R7 random read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    logic [7:0] mem_rdata_unused;

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..all: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule